// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block is the 32-bit register file that sits between a host bus and an Ethernet MAC. It holds the operating mode with its receive and transmit enables, the station address, the multicast hash filter, flow control, two VLAN tag words, the wake-up filter set, system control and status, the receive and transmit status, sticky and interrupt-enable words, and the statistics-counter control with its two counter-interrupt status and enable pairs. Packet handling and the counters themselves live elsewhere. The counters are cleared through a one-cycle pulse that this block drives.

Each register has its own write rule. Some words are plain read/write. Some are fully or partially write-one-to-clear. The receive and transmit status words ignore writes. One control bit triggers an action and always reads back as zero. Turning an enable on clears the matching completion flag. Status bits are raised by event inputs from the MAC, and an event wins over a clear in the same cycle. A sixteen-word window for time-sync registers returns zero and ignores writes. Any other unmapped offset, and any address that is not word-aligned, is refused with an error flag.

The bus is word-only. A request is held for one cycle. The response arrives on the next cycle, with `bus_ack` set and, for a read, the data the register held when the request was made. Writes respond with zero read data.

Top module: `emac_csr`

## Requirements
- R1: After reset the words read as follows: 0x04 reads 0xFFFFFFFF, 0x08 reads 0x0000FFFF, 0x18 and 0x1C read 0x0000FFFF, 0x44 reads 0x00003F00, 0x64 reads 0x0000000A, and every other mapped word reads 0. The enable outputs, `bus_ack` and `cnt_clear` are low.
- R2: The plain words store all 32 written bits and read them back. These are mode 0x00, station address 0x04/0x08, hash 0x0C/0x10, flow control 0x14, VLAN 0x18/0x1C, wake filter words 0x24–0x40, system control 0x44, the interrupt enables 0x54/0x60/0x6C/0x74, and the upper bits of 0x64.
- R3: Mode bit 0 is the receive enable and bit 1 is the transmit enable, and both appear on `rx_en` and `tx_en`. A write that takes bit 0 from 0 to 1 clears bit 12 of RX status (0x4C). A write that takes bit 1 from 0 to 1 clears bit 0 of TX status (0x58). A write that leaves an enable at 1 clears nothing.
- R4: In system status (0x48), writing a 1 clears a bit only for bits in mask 0x000000E1. Every other bit keeps its value under any write.
- R5: In wake control (0x20), bits in mask 0x00000F20 clear when written with 1 and are set only by `evt_wake`. All other bits take the written value.
- R6: Writes to RX status (0x4C) and TX status (0x58) have no effect. These words change only through their event inputs and through R3.
- R7: RX sticky (0x50), TX sticky (0x5C), counter RX interrupt status (0x68) and counter TX interrupt status (0x70) clear any bit written with 1, across all 32 bits.
- R8: Writing 1 to bit 0 of counter control (0x64) raises `cnt_clear` for exactly the one cycle after the write is accepted. Bit 0 always reads 0, and bits 31:1 store the written value.
- R9: An event input bit that is high in a cycle sets the matching status bit at the next edge, even if a write in that same cycle clears it.
- R10: An access to a misaligned address, to word 0x78 or 0x7C, or to an offset of 0xC0 or above sets `bus_err` for one cycle together with `bus_ack`. It returns read data 0 and changes no register.
- R11: Offsets 0x80–0xBC read 0, ignore writes and raise no error.
- R12: Every request is answered with `bus_ack` on the next cycle. Read data is the register value in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Response strobe, one cycle after the request |
| bus_err | output | 1 | Invalid-access flag, with bus_ack |
| evt_sys_stat | input | 32 | Event bits that set system status |
| evt_wake | input | 32 | Event bits that set wake control (mask 0xF20 only) |
| evt_rx_stat | input | 32 | Event bits that set RX status |
| evt_rx_sticky | input | 32 | Event bits that set RX sticky |
| evt_tx_stat | input | 32 | Event bits that set TX status |
| evt_tx_sticky | input | 32 | Event bits that set TX sticky |
| evt_cnt_rx_irq | input | 32 | Event bits that set counter RX interrupt status |
| evt_cnt_tx_irq | input | 32 | Event bits that set counter TX interrupt status |
| rx_en | output | 1 | Receive enable (mode bit 0) |
| tx_en | output | 1 | Transmit enable (mode bit 1) |
| cnt_clear | output | 1 | One-cycle statistics-counter clear pulse |

## Verification
The bench targets the places where write rules interact. It clears system status with all ones and expects the bits outside 0xE1 to survive; a design with a full W1C there would lose them. It writes wake control so that both the W1C bits and the plain bits change in one access; mixing up the two masks would show as wrong bits. It writes the mode register a second time with an enable already on, so a level-triggered clear would wipe a completion flag that an edge-triggered clear keeps. It raises an event in the same cycle as a clearing write, so a clear-wins design would drop the bit. It writes a misaligned address inside a live word, so a decoder that ignores the low address bits would corrupt the hash register.

// File: rtl/emac_csr_pkg.sv
package emac_csr_pkg;

    localparam int DW      = 32;
    localparam int ADDR_W  = 8;
    localparam int NREG    = 30;
    localparam int IDX_W   = $clog2(NREG);
    localparam int TS_FIRST = 32;
    localparam int TS_LAST  = 47;

    // word indices
    localparam int R_MODE    = 0;
    localparam int R_STA_LO  = 1;
    localparam int R_STA_HI  = 2;
    localparam int R_VLAN_A  = 6;
    localparam int R_VLAN_B  = 7;
    localparam int R_WAKE    = 8;
    localparam int R_SYSCTL  = 17;
    localparam int R_SYSSTAT = 18;
    localparam int R_RXSTAT  = 19;
    localparam int R_RXSTKY  = 20;
    localparam int R_TXSTAT  = 22;
    localparam int R_TXSTKY  = 23;
    localparam int R_CNTCTL  = 25;
    localparam int R_CRXIS   = 26;
    localparam int R_CTXIS   = 28;

    localparam int RXEN_BIT    = 0;
    localparam int TXEN_BIT    = 1;
    localparam int RX_DONE_BIT = 12;
    localparam int TX_DONE_BIT = 0;
    localparam int CNT_CLR_BIT = 0;

    localparam logic [DW-1:0] SYS_W1C  = 32'h0000_00E1;
    localparam logic [DW-1:0] WAKE_W1C = 32'h0000_0F20;
    localparam logic [DW-1:0] ALL1     = '1;

    typedef enum logic [1:0] {ACC_REG, ACC_TSYNC, ACC_BAD} acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } decode_t;

    function automatic logic [DW-1:0] reset_of(input int i);
        case (i)
            R_STA_LO:           return 32'hFFFF_FFFF;
            R_STA_HI, R_VLAN_A,
            R_VLAN_B:           return 32'h0000_FFFF;
            R_SYSCTL:           return 32'h0000_3F00;
            R_CNTCTL:           return 32'h0000_000A;
            default:            return '0;
        endcase
    endfunction

    // bits cleared by a written one
    function automatic logic [DW-1:0] w1c_of(input int i);
        case (i)
            R_SYSSTAT:                          return SYS_W1C;
            R_WAKE:                             return WAKE_W1C;
            R_RXSTKY, R_TXSTKY, R_CRXIS, R_CTXIS: return ALL1;
            default:                            return '0;
        endcase
    endfunction

    // bits that take the written value
    function automatic logic [DW-1:0] wrm_of(input int i);
        case (i)
            R_SYSSTAT, R_RXSTAT, R_TXSTAT,
            R_RXSTKY, R_TXSTKY, R_CRXIS, R_CTXIS: return '0;
            R_WAKE:                             return ~WAKE_W1C;
            R_CNTCTL:                           return ~(DW'(1) << CNT_CLR_BIT);
            default:                            return ALL1;
        endcase
    endfunction

    // bits that event inputs may set
    function automatic logic [DW-1:0] setm_of(input int i);
        case (i)
            R_SYSSTAT, R_RXSTAT, R_TXSTAT,
            R_RXSTKY, R_TXSTKY, R_CRXIS, R_CTXIS: return ALL1;
            R_WAKE:                             return WAKE_W1C;
            default:                            return '0;
        endcase
    endfunction

endpackage

// File: rtl/emac_csr_decode.sv
module emac_csr_decode
    import emac_csr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output decode_t       dec
);
    localparam int WORD_W = AW - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[AW-1:2];

    always_comb begin
        dec.idx  = word[IDX_W-1:0];
        dec.kind = ACC_BAD;
        if (addr[1:0] == 2'b00) begin
            if (int'(word) < NREG)
                dec.kind = ACC_REG;
            else if (int'(word) >= TS_FIRST && int'(word) <= TS_LAST)
                dec.kind = ACC_TSYNC;
        end
    end
endmodule

// File: rtl/emac_csr_cell.sv
module emac_csr_cell
    import emac_csr_pkg::*;
#(
    parameter logic [DW-1:0] RST  = '0,
    parameter logic [DW-1:0] W1C  = '0,
    parameter logic [DW-1:0] WRM  = '1,
    parameter logic [DW-1:0] SETM = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] set,
    input  logic [DW-1:0] hclr,
    output logic [DW-1:0] q
);
    logic [DW-1:0] nxt;

    always_comb begin
        nxt = q;
        if (we) begin
            nxt = nxt & ~(wdata & W1C);
            nxt = (nxt & ~WRM) | (wdata & WRM);
        end
        nxt = nxt & ~hclr;
        nxt = nxt | (set & SETM);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST;
        else     q <= nxt;
    end

    generate
        if (SETM != '0) begin : g_set_chk
            // R9: an event bit is present after the edge, whatever the write did
            p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
                ((set & SETM) != '0) |=> ((q & $past(set & SETM)) == $past(set & SETM)));
        end
        if (WRM == '0 && W1C == '0) begin : g_ro_chk
            // R6: a write alone leaves a read-only status word unchanged
            p_ro_hold_r6: assert property (@(posedge clk) disable iff (rst)
                (we && (set & SETM) == '0 && hclr == '0) |=> (q == $past(q)));
        end
    endgenerate
endmodule

// File: rtl/emac_csr.sv
module emac_csr
    import emac_csr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_ack,
    output logic          bus_err,
    input  logic [31:0]   evt_sys_stat,
    input  logic [31:0]   evt_wake,
    input  logic [31:0]   evt_rx_stat,
    input  logic [31:0]   evt_rx_sticky,
    input  logic [31:0]   evt_tx_stat,
    input  logic [31:0]   evt_tx_sticky,
    input  logic [31:0]   evt_cnt_rx_irq,
    input  logic [31:0]   evt_cnt_tx_irq,
    output logic          rx_en,
    output logic          tx_en,
    output logic          cnt_clear
);
    logic [DW-1:0] q      [NREG];
    logic [DW-1:0] set_v  [NREG];
    logic [DW-1:0] hclr_v [NREG];
    logic [DW-1:0] rd_mux;
    decode_t       dec;
    logic          wr_hit, rx_rise, tx_rise;

    emac_csr_decode #(.AW(ADDR_W)) u_dec (.addr(bus_addr), .dec(dec));

    assign wr_hit  = bus_req && bus_we && (dec.kind == ACC_REG);
    assign rx_rise = wr_hit && (dec.idx == IDX_W'(R_MODE)) &&
                     bus_wdata[RXEN_BIT] && !q[R_MODE][RXEN_BIT];
    assign tx_rise = wr_hit && (dec.idx == IDX_W'(R_MODE)) &&
                     bus_wdata[TXEN_BIT] && !q[R_MODE][TXEN_BIT];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            set_v[i]  = '0;
            hclr_v[i] = '0;
        end
        set_v[R_SYSSTAT] = evt_sys_stat;
        set_v[R_WAKE]    = evt_wake;
        set_v[R_RXSTAT]  = evt_rx_stat;
        set_v[R_RXSTKY]  = evt_rx_sticky;
        set_v[R_TXSTAT]  = evt_tx_stat;
        set_v[R_TXSTKY]  = evt_tx_sticky;
        set_v[R_CRXIS]   = evt_cnt_rx_irq;
        set_v[R_CTXIS]   = evt_cnt_tx_irq;
        hclr_v[R_RXSTAT][RX_DONE_BIT] = rx_rise;
        hclr_v[R_TXSTAT][TX_DONE_BIT] = tx_rise;
    end

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            emac_csr_cell #(
                .RST (reset_of(i)),
                .W1C (w1c_of(i)),
                .WRM (wrm_of(i)),
                .SETM(setm_of(i))
            ) u_cell (
                .clk  (clk),
                .rst  (rst),
                .we   (wr_hit && (dec.idx == IDX_W'(i))),
                .wdata(bus_wdata),
                .set  (set_v[i]),
                .hclr (hclr_v[i]),
                .q    (q[i])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++)
            if (dec.idx == IDX_W'(i)) rd_mux = q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
            cnt_clear <= 1'b0;
        end else begin
            bus_ack   <= bus_req;
            bus_err   <= bus_req && (dec.kind == ACC_BAD);
            bus_rdata <= (bus_req && !bus_we && dec.kind == ACC_REG) ? rd_mux : '0;
            cnt_clear <= wr_hit && (dec.idx == IDX_W'(R_CNTCTL)) && bus_wdata[CNT_CLR_BIT];
        end
    end

    assign rx_en = q[R_MODE][RXEN_BIT];
    assign tx_en = q[R_MODE][TXEN_BIT];

    p_ack_next_r12: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_ack);

    p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_ack && bus_rdata == '0));

    p_rx_done_clr_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_en) && !$past(evt_rx_stat[RX_DONE_BIT])) |-> !q[R_RXSTAT][RX_DONE_BIT]);

    p_clr_from_write_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_clear |-> $past(bus_req && bus_we && bus_wdata[CNT_CLR_BIT]));

    p_clr_bit_zero_r8: assert property (@(posedge clk) disable iff (rst)
        $past(bus_req && bus_we) |-> !q[R_CNTCTL][CNT_CLR_BIT]);
endmodule

// File: tb/emac_csr_test.sv
module emac_csr_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_err;
    logic [31:0] evt_sys_stat = '0, evt_wake = '0, evt_rx_stat = '0, evt_rx_sticky = '0;
    logic [31:0] evt_tx_stat = '0, evt_tx_sticky = '0, evt_cnt_rx_irq = '0, evt_cnt_tx_irq = '0;
    logic        rx_en, tx_en, cnt_clear;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    emac_csr uut (.*);

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h04, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h08, 32'h0, 32'h0000_FFFF, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h18, 32'h0, 32'h0000_FFFF, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h1C, 32'h0, 32'h0000_FFFF, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h44, 32'h0, 32'h0000_3F00, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h64, 32'h0, 32'h0000_000A, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h00, 32'h0, 32'h0,         1'b0, 4'd1},  // R1
        '{1'b1, 8'h0C, 32'h1234_5678, 32'h0, 1'b0, 4'd2},  // R2
        '{1'b0, 8'h0C, 32'h0, 32'h1234_5678, 1'b0, 4'd2},  // R2
        '{1'b1, 8'h3C, 32'hA5A5_0F0F, 32'h0, 1'b0, 4'd2},  // R2
        '{1'b0, 8'h3C, 32'h0, 32'hA5A5_0F0F, 1'b0, 4'd2},  // R2
        '{1'b1, 8'h4C, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd6},  // R6
        '{1'b0, 8'h4C, 32'h0, 32'h0,         1'b0, 4'd6},  // R6
        '{1'b1, 8'h78, 32'h1, 32'h0,         1'b1, 4'd10}, // R10
        '{1'b0, 8'hC0, 32'h0, 32'h0,         1'b1, 4'd10}, // R10
        '{1'b0, 8'h02, 32'h0, 32'h0,         1'b1, 4'd10}, // R10
        '{1'b1, 8'h80, 32'hDEAD_BEEF, 32'h0, 1'b0, 4'd11}, // R11
        '{1'b0, 8'h80, 32'h0, 32'h0,         1'b0, 4'd11}, // R11
        '{1'b1, 8'h64, 32'h0000_00F0, 32'h0, 1'b0, 4'd8},  // R8
        '{1'b0, 8'h64, 32'h0, 32'h0000_00F0, 1'b0, 4'd8},  // R8
        '{1'b1, 8'h20, 32'h0000_F0FF, 32'h0, 1'b0, 4'd5},  // R5
        '{1'b0, 8'h20, 32'h0, 32'h0000_F0DF, 1'b0, 4'd5}   // R5
    };

    task automatic check(input int r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
        end
    endtask

    // one bus access; returns sampled response at the following falling edge
    task automatic access(input logic we, input logic [7:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output logic ack, output logic err);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        rd = bus_rdata; ack = bus_ack; err = bus_err;
    endtask

    task automatic rd_chk(input int r, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic ack, err;
        access(1'b0, a, 32'h0, rd, ack, err);
        check(r, rd, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] rd; logic ack, err;
        access(1'b1, a, wd, rd, ack, err);
    endtask

    task automatic pulse_evt(input int which, input logic [31:0] v);
        @(negedge clk);
        case (which)
            0: evt_sys_stat = v;   1: evt_wake = v;
            2: evt_rx_stat = v;    3: evt_rx_sticky = v;
            4: evt_tx_stat = v;    default: evt_cnt_tx_irq = v;
        endcase
        @(negedge clk);
        evt_sys_stat = '0; evt_wake = '0; evt_rx_stat = '0;
        evt_rx_sticky = '0; evt_tx_stat = '0; evt_cnt_tx_irq = '0;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd; logic ack, err;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state of outputs
        check(1, {29'h0, rx_en, tx_en, cnt_clear}, 32'h0);
        check(1, {31'h0, bus_ack}, 32'h0);

        // table walk: R1 R2 R5 R6 R8 R10 R11 R12
        for (int k = 0; k < NV; k++) begin
            access(VECS[k].we, VECS[k].addr, VECS[k].wd, rd, ack, err);
            check(int'(VECS[k].req), rd, VECS[k].exp);
            check(int'(VECS[k].req), {31'h0, err}, {31'h0, VECS[k].err});
            check(12, {31'h0, ack}, 32'h1); // R12
        end

        // R10: misaligned write inside the hash word changes nothing
        access(1'b1, 8'h0E, 32'hFFFF_0000, rd, ack, err);
        check(10, {31'h0, err}, 32'h1);
        rd_chk(10, 8'h0C, 32'h1234_5678);

        // R4: system status W1C only within 0xE1
        pulse_evt(0, 32'h0000_00FF);
        rd_chk(4, 8'h48, 32'h0000_00FF);
        wr(8'h48, 32'hFFFF_FFFF);
        rd_chk(4, 8'h48, 32'h0000_001E);

        // R5: wake events only on 0xF20, then mixed write
        pulse_evt(1, 32'hFFFF_FFFF);
        rd_chk(5, 8'h20, 32'h0000_FFFF);
        wr(8'h20, 32'h0000_0120);
        rd_chk(5, 8'h20, 32'h0000_0E00);

        // R7: full W1C on sticky and counter interrupt status
        pulse_evt(3, 32'hFFFF_FFFF);
        wr(8'h50, 32'h0F0F_0F0F);
        rd_chk(7, 8'h50, 32'hF0F0_F0F0);
        pulse_evt(5, 32'h0000_00FF);
        wr(8'h70, 32'h0000_0081);
        rd_chk(7, 8'h70, 32'h0000_007E);

        // R9: event in the same cycle as a clearing write
        @(negedge clk);
        evt_rx_sticky = 32'h8000_0000;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h50; bus_wdata = 32'hF000_0000;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; evt_rx_sticky = '0;
        rd_chk(9, 8'h50, 32'h80F0_F0F0);

        // R3: enable rising edges clear completion flags
        pulse_evt(2, 32'h0000_1001);
        rd_chk(6, 8'h4C, 32'h0000_1001);
        wr(8'h00, 32'h0000_0001);
        check(3, {31'h0, rx_en}, 32'h1);
        rd_chk(3, 8'h4C, 32'h0000_0001);
        pulse_evt(2, 32'h0000_1000);
        pulse_evt(4, 32'h0000_0003);
        wr(8'h00, 32'h0000_0003);
        check(3, {30'h0, tx_en, rx_en}, 32'h3);
        rd_chk(3, 8'h4C, 32'h0000_1001);
        rd_chk(3, 8'h58, 32'h0000_0002);

        // R8: counter clear pulse lasts one cycle
        access(1'b1, 8'h64, 32'h0000_0031, rd, ack, err);
        check(8, {31'h0, cnt_clear}, 32'h1);
        @(negedge clk);
        check(8, {31'h0, cnt_clear}, 32'h0);
        rd_chk(8, 8'h64, 32'h0000_0030);
        access(1'b1, 8'h64, 32'h0000_0030, rd, ack, err);
        check(8, {31'h0, cnt_clear}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule